// File: doc/BRIEF.md
# Word-Serial Adder Test Harness

This block wraps a wide two-operand adder so that every operand bit and every result bit sits in a flip-flop. The adder delay is then purely register to register. Operands are too wide to bring to pins directly. Instead they are written one 32-bit word at a time through a narrow input bus into two 256-bit operand registers. A single capture strobe moves the 257-bit result, which is the sum plus the carry-out, into a result register. The result is then read back one word at a time through a 32-bit output register.

The adder core is a separate submodule with a fixed port list. Any adder architecture with the same ports can replace it while the harness stays as it is. The top-level pin count is about 75 signals, which fits a small programmable device.

Top module: `adderHarness`

## Requirements
- R1: A synchronous reset clears both operand registers, the result register and dataOut to zero.
- R2: When loadEn is high at a rising edge, dataIn is written into bits [32*wordIdx+31 : 32*wordIdx] of operand A if opSel is 0, or of operand B if opSel is 1. All other words of both operands keep their values.
- R3: When loadEn is low, neither operand changes, whatever opSel, wordIdx and dataIn do.
- R4: When captureEn is high at a rising edge, the result register takes the 257-bit sum of the operands as they stood before that edge. A load in the same cycle is not part of that capture.
- R5: When captureEn is low, the result register holds its value.
- R6: dataOut is registered. For a readIdx value k from 0 to 7 at a rising edge, dataOut after that edge equals result bits [32k+31 : 32k].
- R7: For readIdx equal to 8, dataOut carries the carry-out in bit 0 and zeros in bits 31:1.
- R8: For readIdx values 9 to 15, dataOut is zero.
- R9: A carry propagates across every 32-bit word boundary, through all 256 bits and into the carry-out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| loadEn | input | 1 | Write dataIn into an operand word |
| opSel | input | 1 | Operand target: 0 selects A, 1 selects B |
| wordIdx | input | 3 | Operand word position for the write |
| dataIn | input | 32 | Operand word data |
| captureEn | input | 1 | Clock the adder output into the result register |
| readIdx | input | 4 | Selects the result word (0-7), the carry (8) or zero (9-15) |
| dataOut | output | 32 | Registered readout word |

## Verification
An operand write can land in the same cycle as a capture, and a readout can land in the same cycle as a capture. The bench provokes both at once. It raises loadEn with a new word for operand A and also strobes captureEn while readIdx points at word 0. It then expects dataOut to show the previous result word, and the captured result to be the sum of the operands before the write. A second capture must then show the sum with the new word included.

// File: rtl/harnessPkg.sv
package harnessPkg;

  typedef struct packed {
    logic loadA;
    logic loadB;
    logic capture;
  } harnessStrobe_t;

endpackage

// File: rtl/addCore.sv
// Pluggable adder core: fixed port list, chained word-wide ripple segments.
module addCore #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 8,
  localparam int OP_W     = WORD_W * NUM_WORDS
) (
  input  logic [OP_W-1:0] opA,
  input  logic [OP_W-1:0] opB,
  output logic [OP_W-1:0] sum,
  output logic            carryOut
);

  logic [NUM_WORDS:0] segCarry;

  assign segCarry[0] = 1'b0;

  // R9: each segment passes its carry to the next one
  for (genvar s = 0; s < NUM_WORDS; s++) begin : gSeg
    logic [WORD_W:0] segSum;
    assign segSum = {1'b0, opA[s*WORD_W +: WORD_W]}
                  + {1'b0, opB[s*WORD_W +: WORD_W]}
                  + {{WORD_W{1'b0}}, segCarry[s]};
    assign sum[s*WORD_W +: WORD_W] = segSum[WORD_W-1:0];
    assign segCarry[s+1]           = segSum[WORD_W];
  end

  assign carryOut = segCarry[NUM_WORDS];

endmodule

// File: rtl/harnessCtrl.sv
module harnessCtrl
  import harnessPkg::*;
#(
  parameter int NUM_WORDS = 8,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic                 loadEn,
  input  logic                 opSel,
  input  logic [IDX_W-1:0]     wordIdx,
  input  logic                 captureEn,
  output harnessStrobe_t       strobe,
  output logic [NUM_WORDS-1:0] wordSel
);

  always_comb begin
    strobe.loadA   = loadEn && !opSel;
    strobe.loadB   = loadEn &&  opSel;
    strobe.capture = captureEn;
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : gDec
    assign wordSel[w] = loadEn && (wordIdx == IDX_W'(w));
  end

  always_comb begin
    AST_ONE_OPERAND: assert (!(strobe.loadA && strobe.loadB)); // R2
    AST_ONE_WORD: assert ($onehot0(wordSel)); // R2
    AST_IDLE_NO_WORD: assert (loadEn || (wordSel == '0)); // R3
  end

endmodule

// File: rtl/harnessDatapath.sv
module harnessDatapath
  import harnessPkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 8,
  localparam int OP_W     = WORD_W * NUM_WORDS,
  localparam int RD_W     = $clog2(NUM_WORDS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  harnessStrobe_t       strobe,
  input  logic [NUM_WORDS-1:0] wordSel,
  input  logic [WORD_W-1:0]    dataIn,
  input  logic [RD_W-1:0]      readIdx,
  output logic [WORD_W-1:0]    dataOut
);

  logic [WORD_W-1:0] wordsA [NUM_WORDS];
  logic [WORD_W-1:0] wordsB [NUM_WORDS];
  logic [OP_W-1:0]   opA, opB, coreSum;
  logic              coreCarry;
  logic [OP_W:0]     resultReg;
  logic [WORD_W-1:0] readMux;

  // R2 R3: word-wise operand registers
  for (genvar w = 0; w < NUM_WORDS; w++) begin : gWord
    always_ff @(posedge clk) begin
      if (rst) begin
        wordsA[w] <= '0;
        wordsB[w] <= '0;
      end else begin
        if (strobe.loadA && wordSel[w]) wordsA[w] <= dataIn;
        if (strobe.loadB && wordSel[w]) wordsB[w] <= dataIn;
      end
    end
    assign opA[w*WORD_W +: WORD_W] = wordsA[w];
    assign opB[w*WORD_W +: WORD_W] = wordsB[w];
  end

  addCore #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) uCore (
    .opA     (opA),
    .opB     (opB),
    .sum     (coreSum),
    .carryOut(coreCarry)
  );

  // R4 R5: result capture
  always_ff @(posedge clk) begin
    if (rst)                 resultReg <= '0;
    else if (strobe.capture) resultReg <= {coreCarry, coreSum};
  end

  // R6 R7 R8: readout selection
  always_comb begin
    readMux = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (readIdx == RD_W'(w)) readMux = resultReg[w*WORD_W +: WORD_W];
    end
    if (readIdx == RD_W'(NUM_WORDS)) readMux = {{(WORD_W-1){1'b0}}, resultReg[OP_W]};
  end

  always_ff @(posedge clk) begin
    if (rst) dataOut <= '0;
    else     dataOut <= readMux;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) $past(rst) |-> (dataOut == '0 && resultReg == '0)); // R1
  AST_CAPTURE_TAKES_CORE: assert property (@(posedge clk) disable iff (rst) strobe.capture |=> resultReg == $past({coreCarry, coreSum})); // R4
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst) !strobe.capture |=> $stable(resultReg)); // R5
  AST_OPERANDS_HOLD: assert property (@(posedge clk) disable iff (rst) (!strobe.loadA && !strobe.loadB) |=> ($stable(opA) && $stable(opB))); // R3
  AST_CARRY_WORD: assert property (@(posedge clk) disable iff (rst) readIdx == RD_W'(NUM_WORDS) |=> dataOut[WORD_W-1:1] == '0); // R7
  AST_HIGH_IDX_ZERO: assert property (@(posedge clk) disable iff (rst) readIdx > RD_W'(NUM_WORDS) |=> dataOut == '0); // R8

endmodule

// File: rtl/adderHarness.sv
module adderHarness
  import harnessPkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 8,
  localparam int IDX_W    = $clog2(NUM_WORDS),
  localparam int RD_W     = $clog2(NUM_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic              opSel,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              captureEn,
  input  logic [RD_W-1:0]   readIdx,
  output logic [WORD_W-1:0] dataOut
);

  harnessStrobe_t       strobe;
  logic [NUM_WORDS-1:0] wordSel;

  harnessCtrl #(.NUM_WORDS(NUM_WORDS)) uCtrl (
    .loadEn   (loadEn),
    .opSel    (opSel),
    .wordIdx  (wordIdx),
    .captureEn(captureEn),
    .strobe   (strobe),
    .wordSel  (wordSel)
  );

  harnessDatapath #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) uPath (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .wordSel(wordSel),
    .dataIn (dataIn),
    .readIdx(readIdx),
    .dataOut(dataOut)
  );

endmodule

// File: tb/tb_adderHarness.sv
`timescale 1ns/1ps
module tb_adderHarness;

  logic        clk = 1'b0;
  logic        rst;
  logic        loadEn, opSel, captureEn;
  logic [2:0]  wordIdx;
  logic [31:0] dataIn;
  logic [3:0]  readIdx;
  logic [31:0] dataOut;

  int checks = 0;
  int fails  = 0;

  logic [255:0] refA, refB;
  logic [256:0] refResult;

  adderHarness dut (
    .clk(clk), .rst(rst), .loadEn(loadEn), .opSel(opSel), .wordIdx(wordIdx),
    .dataIn(dataIn), .captureEn(captureEn), .readIdx(readIdx), .dataOut(dataOut)
  );

  always #5 clk = ~clk;

  function automatic logic [256:0] refSum();
    return {1'b0, refA} + {1'b0, refB};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: dataOut=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadWord(bit sel, int idx, logic [31:0] d);
    @(negedge clk);
    loadEn = 1'b1; opSel = sel; wordIdx = 3'(idx); dataIn = d;
    @(negedge clk);
    loadEn = 1'b0;
    if (sel) refB[idx*32 +: 32] = d; else refA[idx*32 +: 32] = d;
  endtask

  task automatic doCapture();
    @(negedge clk);
    captureEn = 1'b1;
    @(negedge clk);
    captureEn = 1'b0;
    refResult = refSum();
  endtask

  task automatic readCheck(int idx, logic [31:0] exp, string req);
    @(negedge clk);
    readIdx = 4'(idx);
    @(negedge clk);
    check(req, dataOut, exp);
  endtask

  task automatic checkAll(string req);
    for (int w = 0; w < 8; w++) readCheck(w, refResult[w*32 +: 32], req);
    readCheck(8, {31'b0, refResult[256]}, {req, " R7"});
  endtask

  task automatic loadBoth(logic [255:0] a, logic [255:0] b);
    for (int w = 0; w < 8; w++) begin
      loadWord(1'b0, w, a[w*32 +: 32]);
      loadWord(1'b1, w, b[w*32 +: 32]);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; loadEn = 1'b0; opSel = 1'b0; wordIdx = '0; dataIn = '0;
    captureEn = 1'b0; readIdx = '0;
    refA = '0; refB = '0; refResult = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    checkAll("R1");

    // R2: each word of each operand in isolation, other operand zero
    for (int s = 0; s < 2; s++) begin
      for (int w = 0; w < 8; w++) begin
        logic [31:0] pat;
        pat = 32'hA5000000 ^ (32'(w) << 8) ^ 32'(s);
        loadWord(s[0], w, pat);
        doCapture();
        checkAll("R2 R6");
        loadWord(s[0], w, 32'h0);
      end
    end

    // R9: carry rippling through every word into carry-out
    loadBoth({256{1'b1}}, 256'd1);
    doCapture();
    checkAll("R9");
    loadBoth({8{32'hFFFFFFFF}} ^ {7'b0, 1'b1, 248'b0}, {8{32'h00000001}});
    doCapture();
    checkAll("R9");

    // R8: indexes above the carry word
    for (int k = 9; k < 16; k++) readCheck(k, 32'h0, "R8");

    // R4 R6: random operand pairs
    for (int n = 0; n < 24; n++) begin
      logic [255:0] ra, rb;
      for (int w = 0; w < 8; w++) begin
        ra[w*32 +: 32] = $urandom;
        rb[w*32 +: 32] = $urandom;
      end
      if (n == 0) begin ra = '1; rb = '1; end
      loadBoth(ra, rb);
      doCapture();
      checkAll("R4");
    end

    // R3: wiggle load fields with loadEn low, then recapture
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      opSel = k[0]; wordIdx = 3'(k); dataIn = $urandom;
    end
    doCapture();
    checkAll("R3");

    // R5: result holds without capture while operands change
    loadWord(1'b0, 3, 32'h12345678);
    loadWord(1'b1, 6, 32'hCAFEF00D);
    repeat (4) @(negedge clk);
    checkAll("R5");

    // R4 R6: load, capture and readout in the same cycle
    begin
      logic [256:0] oldResult, preLoad;
      oldResult = refResult;
      preLoad   = refSum();
      @(negedge clk);
      loadEn = 1'b1; opSel = 1'b0; wordIdx = 3'd0; dataIn = 32'hDEADBEEF;
      captureEn = 1'b1; readIdx = 4'd0;
      @(negedge clk);
      loadEn = 1'b0; captureEn = 1'b0;
      check("R6 same-cycle readout", dataOut, oldResult[31:0]);
      refA[31:0] = 32'hDEADBEEF;
      refResult  = preLoad;
      checkAll("R4 same-cycle capture");
      doCapture();
      checkAll("R4 after same-cycle load");
    end

    // R1: mid-run reset clears operands and result
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 dataOut after reset", dataOut, 32'h0);
    refA = '0; refB = '0; refResult = '0;
    checkAll("R1");
    doCapture();
    checkAll("R1 operands cleared");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule